// File: doc/BRIEF.md
# Single-Channel Block DMA Engine

This block moves a contiguous run of memory words from one place to another without the processor touching each word. Software loads a source word address, a destination word address and a word count through a small register port. It then writes a start bit. The engine asks the processor for the memory bus and waits until the processor hands the bus over. It confirms the hand-over and then copies the block, one word at a time. Each word is a read from the source followed by a write of that value to the destination.

Once the final word has been written, the engine gives the bus back through a release request and waits for the processor to confirm it. It then flags completion, and it raises an interrupt line if interrupts are enabled. The memory side is a plain synchronous request bus. The engine holds `mem_valid` and the request fields steady until the memory answers with `mem_ready`.

Top module: `dmac_top`

## Requirements
- R1: After reset every register reads zero, and `irq`, `bus_req`, `bus_gnt_ack`, `bus_rel` and `mem_valid` are low. The register selector `cfg_sel` picks the register: 0 = source address, 1 = destination address, 2 = remaining word count, 3 = control. A control write uses bit 0 = start, bit 1 = interrupt enable and bit 2 = clear done (write one). A control read returns bit 0 = busy, bit 1 = interrupt enable and bit 2 = done.
- R2: A start write made with a nonzero count raises `bus_req` in the cycle after the write. No memory access is made before the grant is handled.
- R3: `bus_gnt_ack` is a one-cycle pulse. It comes in the cycle after `bus_gnt` is first sampled high. The first memory access begins in the cycle after that pulse, and `mem_valid` is only ever high while the grant is held.
- R4: Each word is moved in two steps. First comes a read at the current source address, then a write of that same value to the current destination address. Each access holds its valid, address, direction and write data steady until `mem_ready`. No word beyond the block is written.
- R5: Each accepted write advances the source and destination addresses by one and lowers the count by one. At the end, the source and destination registers read their start values plus the count, and the count reads zero.
- R6: In the cycle after the last write is accepted, `bus_req` falls and `bus_rel` rises. `bus_rel` stays high until `bus_rel_ack`. On the clock edge that samples `bus_rel_ack`, busy clears and done sets.
- R7: `irq` is high exactly while done and interrupt enable are both set. It stays high until software clears done, and an enable written after done has already set also raises it.
- R8: A start write made with a count of zero sets done on the next edge and never raises `bus_req`.
- R9: While busy, writes to any register are ignored, including a control write that would clear done, disable the interrupt or restart.
- R10: `bus_req` stays high from the request until the last write is accepted. `bus_req` and `bus_rel` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register selector |
| cfg_wdata | input | RW | Register write data |
| cfg_rdata | output | RW | Read data of the selected register |
| bus_req | output | 1 | Bus ownership request to the processor |
| bus_gnt | input | 1 | Bus grant from the processor |
| bus_gnt_ack | output | 1 | One-cycle grant acknowledge |
| bus_rel | output | 1 | Bus release request |
| bus_rel_ack | input | 1 | Processor acknowledges the release |
| mem_valid | output | 1 | Memory access request |
| mem_write | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Word address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, taken when `mem_ready` is high |
| mem_ready | input | 1 | Memory completes the current access |
| irq | output | 1 | Completion interrupt |

## Verification
A register write from software can land in the same cycle as a word step. The word step moves the addresses and decrements the count, while the write tries to overwrite those same registers. The bench provokes this by stalling the memory for several cycles per access and issuing writes to the source address, the count and the control register in the middle of a block. Correct behaviour is judged at the end: the registers must read exactly start value plus count, the interrupt must still be enabled, and the destination must hold an untouched copy of the source.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    // register selector values
    typedef enum logic [1:0] {
        SEL_SRC = 2'd0,
        SEL_DST = 2'd1,
        SEL_CNT = 2'd2,
        SEL_CTL = 2'd3
    } reg_sel_e;

    // control write bits
    localparam int CW_START = 0;
    localparam int CW_IEN   = 1;
    localparam int CW_CLR   = 2;

    // bus ownership sequence
    typedef enum logic [2:0] {
        OWN_IDLE,
        OWN_REQ,
        OWN_ACK,
        OWN_HOLD,
        OWN_REL
    } own_st_e;

    // word mover phase
    typedef enum logic {
        PH_READ,
        PH_WRITE
    } move_ph_e;

    typedef struct packed {
        logic done;
        logic ien;
        logic busy;
    } ctl_t;

    function automatic logic [2:0] status_bits(ctl_t c);
        return {c.done, c.ien, c.busy};
    endfunction

endpackage

// File: rtl/dmac_cfg.sv
module dmac_cfg
    import dmac_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int RW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we_i,
    input  logic [1:0]    sel_i,
    input  logic [RW-1:0] wdata_i,
    output logic [RW-1:0] rdata_o,
    input  logic          step_i,
    input  logic          finished_i,
    output logic          go_o,
    output logic [AW-1:0] src_o,
    output logic [AW-1:0] dst_o,
    output logic          last_o,
    output logic          irq_o
);

    logic [AW-1:0] src_q, dst_q;
    logic [CW-1:0] cnt_q;
    ctl_t          ctl_q;
    reg_sel_e      sel;
    logic          wr_ok, start_w;

    assign sel     = reg_sel_e'(sel_i);
    assign wr_ok   = we_i && !ctl_q.busy;
    assign start_w = wr_ok && (sel == SEL_CTL) && wdata_i[CW_START];
    assign go_o    = start_w && (cnt_q != '0);
    assign src_o   = src_q;
    assign dst_o   = dst_q;
    assign last_o  = (cnt_q == CW'(1));
    assign irq_o   = ctl_q.done && ctl_q.ien;

    always_comb begin
        unique case (sel)
            SEL_SRC: rdata_o = RW'(src_q);
            SEL_DST: rdata_o = RW'(dst_q);
            SEL_CNT: rdata_o = RW'(cnt_q);
            default: rdata_o = RW'(status_bits(ctl_q));
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q <= '0;
            dst_q <= '0;
            cnt_q <= '0;
            ctl_q <= '0;
        end else begin
            if (wr_ok) begin
                unique case (sel)
                    SEL_SRC: src_q <= wdata_i[AW-1:0];
                    SEL_DST: dst_q <= wdata_i[AW-1:0];
                    SEL_CNT: cnt_q <= wdata_i[CW-1:0];
                    default: begin
                        ctl_q.ien <= wdata_i[CW_IEN];
                        if (wdata_i[CW_CLR]) ctl_q.done <= 1'b0;
                        if (wdata_i[CW_START]) begin
                            if (cnt_q == '0) begin
                                ctl_q.done <= 1'b1;
                            end else begin
                                ctl_q.busy <= 1'b1;
                                ctl_q.done <= 1'b0;
                            end
                        end
                    end
                endcase
            end
            if (step_i) begin
                src_q <= src_q + 1'b1;
                dst_q <= dst_q + 1'b1;
                cnt_q <= cnt_q - 1'b1;
            end
            if (finished_i) begin
                ctl_q.busy <= 1'b0;
                ctl_q.done <= 1'b1;
            end
        end
    end

    // R5
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        step_i |=> cnt_q == $past(cnt_q) - 1'b1);

    // R9
    busy_lock_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_q.busy && !step_i |=> $stable(src_q) && $stable(dst_q) && $stable(cnt_q));

    // R7
    irq_idle_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> !ctl_q.busy);

    // R2
    go_busy_chk: assert property (@(posedge clk) disable iff (rst)
        go_o |=> ctl_q.busy && !ctl_q.done);

    // R8
    zero_start_chk: assert property (@(posedge clk) disable iff (rst)
        start_w && (cnt_q == '0) |=> ctl_q.done && !ctl_q.busy);

endmodule

// File: rtl/dmac_own.sv
module dmac_own
    import dmac_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic go_i,
    input  logic blk_done_i,
    input  logic bgnt_i,
    input  logic brel_ack_i,
    output logic breq_o,
    output logic bgnt_ack_o,
    output logic brel_o,
    output logic owner_o,
    output logic finished_o
);

    own_st_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            OWN_IDLE: if (go_i)       st_d = OWN_REQ;
            OWN_REQ:  if (bgnt_i)     st_d = OWN_ACK;
            OWN_ACK:                  st_d = OWN_HOLD;
            OWN_HOLD: if (blk_done_i) st_d = OWN_REL;
            OWN_REL:  if (brel_ack_i) st_d = OWN_IDLE;
            default:                  st_d = OWN_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= OWN_IDLE;
        else     st_q <= st_d;
    end

    assign breq_o     = (st_q == OWN_REQ) || (st_q == OWN_ACK) || (st_q == OWN_HOLD);
    assign bgnt_ack_o = (st_q == OWN_ACK);
    assign owner_o    = (st_q == OWN_HOLD);
    assign brel_o     = (st_q == OWN_REL);
    assign finished_o = (st_q == OWN_REL) && brel_ack_i;

    // R10
    req_rel_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(breq_o && brel_o));

    // R3
    ack_after_gnt_chk: assert property (@(posedge clk) disable iff (rst)
        bgnt_ack_o |-> $past(bgnt_i));

    // R3
    ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        bgnt_ack_o |=> !bgnt_ack_o);

    // R6
    rel_after_last_chk: assert property (@(posedge clk) disable iff (rst)
        blk_done_i |=> brel_o && !breq_o);

    // R6
    rel_hold_chk: assert property (@(posedge clk) disable iff (rst)
        brel_o && !brel_ack_i |=> brel_o);

endmodule

// File: rtl/dmac_move.sv
module dmac_move
    import dmac_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          owner_i,
    input  logic [AW-1:0] src_i,
    input  logic [AW-1:0] dst_i,
    input  logic          last_i,
    input  logic          mem_ready_i,
    input  logic [DW-1:0] mem_rdata_i,
    output logic          mem_valid_o,
    output logic          mem_write_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [DW-1:0] mem_wdata_o,
    output logic          step_o,
    output logic          blk_done_o
);

    move_ph_e      ph_q;
    logic [DW-1:0] hold_q;
    logic          in_wr;

    assign in_wr       = (ph_q == PH_WRITE);
    assign mem_valid_o = owner_i;
    assign mem_write_o = owner_i && in_wr;
    assign mem_addr_o  = in_wr ? dst_i : src_i;
    assign mem_wdata_o = hold_q;
    assign step_o      = owner_i && in_wr && mem_ready_i;
    assign blk_done_o  = step_o && last_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_READ;
            hold_q <= '0;
        end else if (!owner_i) begin
            ph_q <= PH_READ;
        end else if (mem_ready_i) begin
            if (!in_wr) begin
                hold_q <= mem_rdata_i;
                ph_q   <= PH_WRITE;
            end else begin
                ph_q   <= PH_READ;
            end
        end
    end

    // R4
    req_steady_chk: assert property (@(posedge clk) disable iff (rst)
        mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_addr_o)
            && $stable(mem_write_o) && $stable(mem_wdata_o));

    // R4
    read_then_write_chk: assert property (@(posedge clk) disable iff (rst)
        mem_valid_o && !mem_write_o && mem_ready_i |=> mem_valid_o && mem_write_o
            && mem_wdata_o == $past(mem_rdata_i));

endmodule

// File: rtl/dmac_top.sv
module dmac_top
    import dmac_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int CW = 16,
    parameter int RW = (AW > CW) ? AW : CW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [RW-1:0] cfg_wdata,
    output logic [RW-1:0] cfg_rdata,
    output logic          bus_req,
    input  logic          bus_gnt,
    output logic          bus_gnt_ack,
    output logic          bus_rel,
    input  logic          bus_rel_ack,
    output logic          mem_valid,
    output logic          mem_write,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ready,
    output logic          irq
);

    logic          go, step, blk_done, owner, finished, last;
    logic [AW-1:0] src, dst;

    dmac_cfg #(.AW(AW), .CW(CW), .RW(RW)) u_cfg (
        .clk        (clk),
        .rst        (rst),
        .we_i       (cfg_we),
        .sel_i      (cfg_sel),
        .wdata_i    (cfg_wdata),
        .rdata_o    (cfg_rdata),
        .step_i     (step),
        .finished_i (finished),
        .go_o       (go),
        .src_o      (src),
        .dst_o      (dst),
        .last_o     (last),
        .irq_o      (irq)
    );

    dmac_own u_own (
        .clk        (clk),
        .rst        (rst),
        .go_i       (go),
        .blk_done_i (blk_done),
        .bgnt_i     (bus_gnt),
        .brel_ack_i (bus_rel_ack),
        .breq_o     (bus_req),
        .bgnt_ack_o (bus_gnt_ack),
        .brel_o     (bus_rel),
        .owner_o    (owner),
        .finished_o (finished)
    );

    dmac_move #(.AW(AW), .DW(DW)) u_move (
        .clk         (clk),
        .rst         (rst),
        .owner_i     (owner),
        .src_i       (src),
        .dst_i       (dst),
        .last_i      (last),
        .mem_ready_i (mem_ready),
        .mem_rdata_i (mem_rdata),
        .mem_valid_o (mem_valid),
        .mem_write_o (mem_write),
        .mem_addr_o  (mem_addr),
        .mem_wdata_o (mem_wdata),
        .step_o      (step),
        .blk_done_o  (blk_done)
    );

    // R10
    mem_under_req_chk: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> bus_req);

    // R7
    irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
        irq && !(cfg_we && cfg_sel == 2'd3) |=> irq);

endmodule

// File: tb/sim_dmac_top.sv
module sim_dmac_top;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 4;
    // fields: src[31:24] dst[23:16] count[15:8] mem_wait[7:4] gnt_wait[3:0]
    localparam logic [31:0] VEC [NV] = '{
        32'h02200500,
        32'h10300123,
        32'h00280811,
        32'h31050330
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        bus_req, bus_gnt_ack, bus_rel;
    logic        bus_gnt = 1'b0;
    logic        bus_rel_ack = 1'b0;
    logic        mem_valid, mem_write;
    logic [15:0] mem_addr, mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic        mem_ready = 1'b0;
    logic        irq;

    logic [15:0] mem [64];
    int init_gen = 0, seen_gen = -1;
    int mwait = 0, gwait = 0, mcnt = 0, gcnt = 0;
    int total = 0, bad = 0;
    int both_bad = 0, nogrant_mem = 0, ack_bad = 0, early_mem = 0;
    logic gnt_prev = 1'b0, ack_prev = 1'b0, req_prev = 1'b0, first_pend = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dmac_top u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_gnt_ack(bus_gnt_ack),
        .bus_rel(bus_rel), .bus_rel_ack(bus_rel_ack),
        .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .irq(irq)
    );

    function automatic logic [15:0] seed(int a);
        return 16'(a * 257) ^ 16'h5A3C;
    endfunction

    // memory and processor models plus protocol monitors, all at negedge
    always @(negedge clk) begin
        if (seen_gen != init_gen) begin
            for (int i = 0; i < 64; i++) mem[i] = seed(i);
            seen_gen = init_gen;
        end
        if (!rst) begin
            if (bus_req && bus_rel) both_bad++;
            if (mem_valid && !bus_gnt) nogrant_mem++;
            if (bus_gnt_ack && (!gnt_prev || ack_prev)) ack_bad++;
            if (bus_req && !req_prev) first_pend = 1'b1;
            if (mem_valid && first_pend) begin
                if (!ack_prev) early_mem++;
                first_pend = 1'b0;
            end
            if (mem_ready) begin
                mem_ready = 1'b0;
                mcnt = 0;
            end else if (mem_valid) begin
                if (mcnt >= mwait) begin
                    mem_ready = 1'b1;
                    if (mem_write) mem[mem_addr[5:0]] = mem_wdata;
                    else           mem_rdata = mem[mem_addr[5:0]];
                end else begin
                    mcnt++;
                end
            end
            if (bus_rel_ack) begin
                bus_rel_ack = 1'b0;
                bus_gnt = 1'b0;
                gcnt = 0;
            end else if (bus_rel && bus_gnt) begin
                bus_rel_ack = 1'b1;
            end else if (bus_req && !bus_gnt) begin
                if (gcnt >= gwait) bus_gnt = 1'b1;
                else gcnt++;
            end
        end
        gnt_prev = bus_gnt;
        ack_prev = bus_gnt_ack;
        req_prev = bus_req;
    end

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        cfg_sel = a;
        #1;
        d = cfg_rdata;
    endtask

    task automatic wait_rel(output logic seen);
        seen = 1'b0;
        for (int k = 0; k < 3000 && !seen; k++) begin
            @(negedge clk);
            if (bus_rel) seen = 1'b1;
        end
    endtask

    task automatic check_copy(input string rq, input int s, input int d, input int n);
        int mism = 0;
        for (int i = 0; i < n; i++)
            if (mem[d + i] !== seed(s + i)) mism++;
        chk({rq, " copy mismatches"}, mism, 0);
        chk({rq, " word past block"}, mem[d + n], seed(d + n));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] d;
        logic seen;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 outputs idle", {irq, bus_req, bus_gnt_ack, bus_rel, mem_valid}, 0);
        for (int r = 0; r < 4; r++) begin
            rd(2'(r), d);
            chk("R1 register reset", d, 0);
        end

        // table of transfers
        for (int v = 0; v < NV; v++) begin
            int s, t, n;
            s = int'(VEC[v][31:24]);
            t = int'(VEC[v][23:16]);
            n = int'(VEC[v][15:8]);
            mwait = int'(VEC[v][7:4]);
            gwait = int'(VEC[v][3:0]);
            init_gen++;
            repeat (2) @(negedge clk);
            wr(2'd0, 16'(s));
            wr(2'd1, 16'(t));
            wr(2'd2, 16'(n));
            wr(2'd3, 16'h0003);
            chk("R2 request after start", {bus_req, mem_valid}, 2'b10);
            wait_rel(seen);
            chk("R6 release seen", seen, 1);
            chk("R6 request dropped at release", bus_req, 0);
            rd(2'd3, d);
            chk("R6 status after release ack", d, 16'h0006);
            chk("R6 release cleared", bus_rel, 0);
            chk("R7 irq on done", irq, 1);
            check_copy("R4", s, t, n);
            rd(2'd0, d); chk("R5 source end", d, 16'(s + n));
            rd(2'd1, d); chk("R5 destination end", d, 16'(t + n));
            rd(2'd2, d); chk("R5 count end", d, 0);
            repeat (3) @(negedge clk);
            chk("R7 irq held", irq, 1);
            wr(2'd3, 16'h0004);
            chk("R7 irq cleared", irq, 0);
        end

        // R8 zero count with interrupt disabled
        wr(2'd2, 16'h0000);
        wr(2'd3, 16'h0001);
        chk("R8 no request on zero count", bus_req, 0);
        rd(2'd3, d);
        chk("R8 done on zero count", d, 16'h0004);
        chk("R7 irq masked", irq, 0);
        wr(2'd3, 16'h0002);
        chk("R7 irq after late enable", irq, 1);
        begin
            int seenreq = 0;
            for (int k = 0; k < 5; k++) begin
                @(negedge clk);
                if (bus_req || mem_valid) seenreq++;
            end
            chk("R8 bus stays idle", seenreq, 0);
        end
        wr(2'd3, 16'h0004);

        // R9 writes during a slow transfer collide with word steps
        mwait = 3;
        gwait = 2;
        init_gen++;
        repeat (2) @(negedge clk);
        wr(2'd0, 16'h0008);
        wr(2'd1, 16'h0038);
        wr(2'd2, 16'h0004);
        wr(2'd3, 16'h0003);
        wr(2'd0, 16'h003F);
        wr(2'd2, 16'h0007);
        wr(2'd3, 16'h0004);
        wr(2'd1, 16'h0000);
        wait_rel(seen);
        chk("R9 transfer completes", seen, 1);
        rd(2'd0, d); chk("R9 source unaffected", d, 16'h000C);
        rd(2'd1, d); chk("R9 destination unaffected", d, 16'h003C);
        rd(2'd2, d); chk("R9 count unaffected", d, 0);
        rd(2'd3, d); chk("R9 control unaffected", d, 16'h0006);
        chk("R9 irq still enabled", irq, 1);
        check_copy("R9", 8, 56, 4);
        wr(2'd3, 16'h0004);

        // protocol monitors
        chk("R10 request and release overlap", both_bad, 0);
        chk("R3 memory access without grant", nogrant_mem, 0);
        chk("R3 grant ack shape", ack_bad, 0);
        chk("R3 first access not after ack", early_mem, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule